// File: doc/BRIEF.md
# Programmable Integer Clock Divider with Half-Cycle Edge Control

This block divides a reference clock by a programmable integer in the range 1 to 128. It has three divider channels: an output counter, a feedback counter and an input divider. Each channel is set by a 14-bit configuration word that holds a high-time count, a low-time count, a bypass bit and an edge bit.

When the edge bit is set, the falling transition of the divided clock moves onto the opposite reference edge. This gives odd ratios an exact 50% duty cycle. When the bypass bit is set, the reference clock goes straight through, which is how divide-by-one is done.

A start bit and a running flag gate the channels. The running flag is set only after every channel has completed one full output period, and it is cleared only after every channel has parked. A configuration word is latched into a channel only when the channel starts, so new settings take effect only after a stop and a fresh start.

A separate combinational encoder converts a plain divide ratio into a configuration word. It marks any illegal ratio with a reserved error code.

Top module: `pclk_div_top`

## Requirements
- R1: For an even ratio r in 2..128, the encoder puts r/2 into both the high field (bits 11:6) and the low field (bits 5:0). Bits 13 (edge) and 12 (bypass) are 0. A count of 64 is written as 0 in its 6-bit field, so ratio 128 encodes as 0x0000.
- R2: For an odd ratio r in 3..127, the high field holds r/2 rounded down and the low field holds that value plus one, with a field value of 0 meaning 64. Bit 13 is 1 and bit 12 is 0. For example, 7 gives 0x20C4 and 127 gives 0x2FC0.
- R3: Ratio 1 encodes as 0x1041: bypass bit set and both counts equal to 1. The error flag stays low.
- R4: Ratio 0 and ratios 129..255 drive the error flag high and encode as 0x3000, with bits 13 and 12 both set. No legal ratio produces that bit pair.
- R5: A running channel with edge and bypass clear drives its clock high for H reference cycles, then low for L reference cycles, where H and L are the high and low fields and a field value of 0 means 64.
- R6: A running channel with the edge bit set and bypass clear stays high for H + 0.5 reference cycles and low for L - 0.5 reference cycles.
- R7: A running channel with the bypass bit set drives the reference clock unchanged onto its output.
- R8: Register map (byte addresses):
  - 0x00: bit 0 is start; reads back.
  - 0x04: bit 0 is running; read-only.
  - 0x08: output-counter word (bits 13:0).
  - 0x0C: feedback-counter word.
  - 0x14: input-divider word.
  - Every other address reads 0.
  - The output, feedback and input channels drive out_clk_o, fb_clk_o and in_clk_o.
- R9: The first reference edge after the start bit is written begins a period with the output high. Running reads 1 exactly one edge after all channels have completed their first full period. For period P, that is edge P+2 counted from the write edge.
- R10: After start is written 0, each channel finishes its current period and then holds its output low. Running reads 0 once all channels have parked, within P+2 edges.
- R11: Words written while a channel runs do not change its output until the next stop and start.
- R12: Reset does the following: all outputs go low, running and start read 0, and every word resets to 0x0041 (divide by two).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address for write and read |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data at reg_addr_i |
| ratio_i | input | RATIO_W | Divide ratio to encode |
| enc_word_o | output | 14 | Encoded configuration word |
| enc_err_o | output | 1 | Ratio outside 1..128 |
| out_clk_o | output | 1 | Output-counter clock |
| fb_clk_o | output | 1 | Feedback-counter clock |
| in_clk_o | output | 1 | Input-divider clock |

## Verification
The encoder is swept over every 8-bit ratio and the results are compared against values computed from R1 to R4. Spot values cover the 64-wraps-to-0 corner and the error code.

The divided clocks are measured in half-cycles so that edge-bit timing is visible. The patterns used are:
- an even symmetric word;
- an asymmetric 3/5 word, which shows that the high and low fields are not swapped;
- odd ratios 3 and 7, which separate edge-bit timing from plain counting;
- bypass, which measures one half-cycle per phase instead of two;
- the all-zero word, which must give a period of 128.

Different words on the three channels show that the address decode is correct. A write made during a run shows that configuration is latched only at start.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;
  localparam int CNT_W   = 6;
  localparam int LEN_W   = CNT_W + 1;
  localparam int PER_W   = CNT_W + 2;
  localparam int WORD_W  = 14;
  localparam int NUM_DIV = 3;

  localparam logic [WORD_W-1:0] ERR_WORD    = 14'h3000;
  localparam logic [WORD_W-1:0] BYPASS_WORD = 14'h1041;
  localparam logic [WORD_W-1:0] RESET_WORD  = 14'h0041;

  localparam logic [7:0] CTRL_OFS = 8'h00;
  localparam logic [7:0] STAT_OFS = 8'h04;
  // channel 0: output, 1: feedback, 2: input divider
  localparam logic [7:0] WORD_OFS [NUM_DIV] = '{8'h08, 8'h0C, 8'h14};

  typedef struct packed {
    logic             edge_sel;
    logic             bypass;
    logic [CNT_W-1:0] high_cnt;
    logic [CNT_W-1:0] low_cnt;
  } div_cfg_t;

  // field value 0 stands for 2**CNT_W
  function automatic logic [LEN_W-1:0] cnt_len(input logic [CNT_W-1:0] f);
    return (f == '0) ? LEN_W'(1 << CNT_W) : {1'b0, f};
  endfunction
endpackage

// File: rtl/pclk_div_encoder.sv
module pclk_div_encoder
  import pclk_div_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               err_o
);
  localparam logic [RATIO_W-1:0] MAX_RATIO = RATIO_W'(1 << (CNT_W + 1));

  logic [RATIO_W-1:0] half;
  logic [RATIO_W-1:0] half_up;
  logic               legal;

  always_comb begin
    half    = ratio_i >> 1;
    half_up = half + RATIO_W'(ratio_i[0]);
    legal   = (ratio_i != '0) && (ratio_i <= MAX_RATIO);
    err_o   = ~legal;
    if (!legal) begin
      word_o = ERR_WORD;
    end else if (ratio_i == RATIO_W'(1)) begin
      word_o = BYPASS_WORD;
    end else begin
      word_o = {ratio_i[0], 1'b0, half[CNT_W-1:0], half_up[CNT_W-1:0]};
    end
  end
endmodule

// File: rtl/pclk_div_counter.sv
module pclk_div_counter
  import pclk_div_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  div_cfg_t cfg_i,
  output logic     clk_o,
  output logic     run_o
);
  logic             active_q, run_q, hi_q, hi_n_q;
  div_cfg_t         cfg_q;
  logic [PER_W-1:0] cnt_q, cnt_inc, period;
  logic [LEN_W-1:0] high_len, low_len;
  logic             wrap;

  always_comb begin
    if (cfg_q.bypass) begin
      high_len = LEN_W'(1);
      low_len  = LEN_W'(1);
    end else begin
      high_len = cnt_len(cfg_q.high_cnt);
      low_len  = cnt_len(cfg_q.low_cnt);
    end
    period  = PER_W'(high_len) + PER_W'(low_len);
    cnt_inc = cnt_q + 1'b1;
    wrap    = (cnt_q == period - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      run_q    <= 1'b0;
      hi_q     <= 1'b0;
      cnt_q    <= '0;
      cfg_q    <= '0;
    end else if (!active_q) begin
      if (en_i) begin
        active_q <= 1'b1;
        cfg_q    <= cfg_i;
        cnt_q    <= '0;
        hi_q     <= 1'b1;
      end
    end else if (wrap) begin
      cnt_q <= '0;
      if (!en_i) begin
        active_q <= 1'b0;
        run_q    <= 1'b0;
        hi_q     <= 1'b0;
      end else begin
        run_q <= 1'b1;
        hi_q  <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_inc;
      hi_q  <= (cnt_inc < PER_W'(high_len));
    end
  end

  // opposite-edge copy stretches the high phase by half a reference cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_n_q <= 1'b0;
    else         hi_n_q <= hi_q;
  end

  assign clk_o = (active_q && cfg_q.bypass) ? clk_i : (hi_q | (cfg_q.edge_sel & hi_n_q));
  assign run_o = run_q;

  assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < period));
  assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (!hi_q && !run_q));
  assert_run_at_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> ($past(cnt_q) == period - 1'b1));
  assert_cfg_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q)) |-> $stable(cfg_q));
endmodule

// File: rtl/pclk_div_regs.sv
module pclk_div_regs
  import pclk_div_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [NUM_DIV-1:0]            run_i,
  output logic                          start_o,
  output div_cfg_t [NUM_DIV-1:0]        cfg_o
);
  logic                   start_q, status_q;
  div_cfg_t [NUM_DIV-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      status_q <= 1'b0;
      for (int i = 0; i < NUM_DIV; i++) word_q[i] <= div_cfg_t'(RESET_WORD);
    end else begin
      if (we_i && addr_i == ADDR_W'(CTRL_OFS)) start_q <= wdata_i[0];
      for (int i = 0; i < NUM_DIV; i++) begin
        if (we_i && addr_i == ADDR_W'(WORD_OFS[i]))
          word_q[i] <= div_cfg_t'(wdata_i[WORD_W-1:0]);
      end
      if (&run_i)       status_q <= 1'b1;
      else if (~|run_i) status_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_OFS)) rdata_o = DATA_W'(start_q);
    if (addr_i == ADDR_W'(STAT_OFS)) rdata_o = DATA_W'(status_q);
    for (int i = 0; i < NUM_DIV; i++) begin
      if (addr_i == ADDR_W'(WORD_OFS[i])) rdata_o = DATA_W'(word_q[i]);
    end
  end

  assign start_o = start_q;
  assign cfg_o   = word_q;

  assert_status_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_q) |-> $past(~|run_i));
  assert_status_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> $past(&run_i));
endmodule

// File: rtl/pclk_div_top.sv
module pclk_div_top
  import pclk_div_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int RATIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [WORD_W-1:0]  enc_word_o,
  output logic               enc_err_o,
  output logic               out_clk_o,
  output logic               fb_clk_o,
  output logic               in_clk_o
);
  logic                   start;
  logic [NUM_DIV-1:0]     run_v, clk_v;
  div_cfg_t [NUM_DIV-1:0] cfg_v;

  pclk_div_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .run_i   (run_v),
    .start_o (start),
    .cfg_o   (cfg_v)
  );

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_chan
    pclk_div_counter u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (start),
      .cfg_i  (cfg_v[g]),
      .clk_o  (clk_v[g]),
      .run_o  (run_v[g])
    );
  end

  assign out_clk_o = clk_v[0];
  assign fb_clk_o  = clk_v[1];
  assign in_clk_o  = clk_v[2];

  pclk_div_encoder #(.RATIO_W(RATIO_W)) u_enc (
    .ratio_i (ratio_i),
    .word_o  (enc_word_o),
    .err_o   (enc_err_o)
  );

  assert_enc_legal_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_err_o |-> !(enc_word_o[13] && enc_word_o[12]));
  assert_enc_err_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_err_o |-> (enc_word_o == ERR_WORD));
endmodule

// File: tb/pclk_div_top_tb_top.sv
`timescale 1ns/1ps
module pclk_div_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [7:0]  ratio_i = '0;
  logic [13:0] enc_word_o;
  logic        enc_err_o, out_clk_o, fb_clk_o, in_clk_o;

  always #2 clk_i = ~clk_i;

  pclk_div_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .ratio_i(ratio_i),
    .enc_word_o(enc_word_o), .enc_err_o(enc_err_o), .out_clk_o(out_clk_o),
    .fb_clk_o(fb_clk_o), .in_clk_o(in_clk_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int    q_hi[$];
  int    q_lo[$];
  string q_tag[$];
  bit    cap = 0;
  int    mon_sel = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // scoreboard monitor: measures high/low runs in half reference cycles
  int m_hi, m_lo;
  bit m_armed = 0, m_wait = 0, m_phase_hi = 0, m_prev = 0;
  always begin
    bit s;
    @(clk_i);
    #1;
    s = (mon_sel == 0) ? out_clk_o : (mon_sel == 1) ? fb_clk_o : in_clk_o;
    if (!cap) m_armed = 0;
    else if (!m_armed) begin
      m_armed = 1; m_wait = 1; m_prev = s;
    end else begin
      if (m_wait) begin
        if (!m_prev && s) begin m_wait = 0; m_phase_hi = 1; m_hi = 1; m_lo = 0; end
      end else if (m_phase_hi) begin
        if (s) m_hi++;
        else begin m_phase_hi = 0; m_lo = 1; end
      end else begin
        if (!s) m_lo++;
        else begin
          if (q_hi.size() > 0) begin
            int eh, el;
            string tg;
            eh = q_hi.pop_front(); el = q_lo.pop_front(); tg = q_tag.pop_front();
            // values shown as hi*1000+lo half-cycles
            chk(m_hi == eh && m_lo == el, tg, m_hi * 1000 + m_lo, eh * 1000 + el);
          end
          m_phase_hi = 1; m_hi = 1; m_lo = 0;
        end
      end
      m_prev = s;
    end
  end

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    step();
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic wait_status(input bit v, output int n);
    logic [31:0] d;
    n = 0;
    reg_read(5'h04, d);
    while (d[0] != v && n < 2000) begin
      step(); n++;
      reg_read(5'h04, d);
    end
  endtask

  task automatic set_all(input logic [13:0] w);
    reg_write(5'h08, {18'd0, w});
    reg_write(5'h0C, {18'd0, w});
    reg_write(5'h14, {18'd0, w});
  endtask

  task automatic start_run(input string tag);
    int n;
    reg_write(5'h00, 32'd1);
    wait_status(1'b1, n);
    chk(n < 2000, tag, n, 0);
  endtask

  task automatic stop_run(input string tag);
    int n;
    reg_write(5'h00, 32'd0);
    wait_status(1'b0, n);
    chk(n < 2000, tag, n, 0);
  endtask

  task automatic expect_periods(input int sel, input int hi, input int lo, input int cnt, input string tag);
    int t = 0;
    mon_sel = sel;
    for (int i = 0; i < cnt; i++) begin
      q_hi.push_back(hi); q_lo.push_back(lo); q_tag.push_back(tag);
    end
    cap = 1;
    while (q_hi.size() > 0 && t < 5000) begin step(); t++; end
    if (q_hi.size() > 0) begin
      chk(0, tag, q_hi.size(), 0);
      q_hi.delete(); q_lo.delete(); q_tag.delete();
    end
    cap = 0;
    step(); step();
  endtask

  function automatic logic [13:0] enc_ref(input int r);
    int h, l;
    if (r < 1 || r > 128) return 14'h3000;
    if (r == 1) return 14'h1041;
    h = r / 2;
    l = h + (r % 2);
    return 14'(((r % 2) << 13) | ((h % 64) << 6) | (l % 64));
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    int bad_even, bad_odd, bad_ill, n;
    repeat (3) step();
    rst_ni = 1'b1;
    step();

    // R12 reset state
    reg_read(5'h08, d); chk(d == 32'h41, "R12 out word reset", d, 32'h41);
    reg_read(5'h0C, d); chk(d == 32'h41, "R12 fb word reset", d, 32'h41);
    reg_read(5'h14, d); chk(d == 32'h41, "R12 in word reset", d, 32'h41);
    reg_read(5'h00, d); chk(d == 0, "R12 start reset", d, 0);
    reg_read(5'h04, d); chk(d == 0, "R12 running reset", d, 0);
    chk({out_clk_o, fb_clk_o, in_clk_o} == 3'b000, "R12 outputs low", {out_clk_o, fb_clk_o, in_clk_o}, 0);

    // encoder sweep R1..R4
    bad_even = 0; bad_odd = 0; bad_ill = 0;
    for (int r = 0; r < 256; r++) begin
      ratio_i = 8'(r);
      #1;
      if (r < 1 || r > 128) begin
        if (enc_word_o != 14'h3000 || !enc_err_o) bad_ill++;
      end else if (r % 2 == 0) begin
        if (enc_word_o != enc_ref(r) || enc_err_o) bad_even++;
      end else if (r > 1) begin
        if (enc_word_o != enc_ref(r) || enc_err_o) bad_odd++;
      end
    end
    chk(bad_even == 0, "R1 even sweep", bad_even, 0);
    chk(bad_odd == 0, "R2 odd sweep", bad_odd, 0);
    chk(bad_ill == 0, "R4 illegal sweep", bad_ill, 0);
    ratio_i = 8'd1;   #1; chk(enc_word_o == 14'h1041 && !enc_err_o, "R3 ratio one", enc_word_o, 14'h1041);
    ratio_i = 8'd128; #1; chk(enc_word_o == 14'h0000, "R1 ratio 128", enc_word_o, 0);
    ratio_i = 8'd7;   #1; chk(enc_word_o == 14'h20C4, "R2 ratio 7", enc_word_o, 14'h20C4);
    ratio_i = 8'd127; #1; chk(enc_word_o == 14'h2FC0, "R2 ratio 127", enc_word_o, 14'h2FC0);
    ratio_i = 8'd0;   #1; chk(enc_word_o == 14'h3000 && enc_err_o, "R4 ratio 0", enc_word_o, 14'h3000);

    // R8 readback and unmapped address
    reg_write(5'h0C, 32'hFFFF_00C5);
    reg_read(5'h0C, d); chk(d == 32'h00C5, "R8 word bits 13:0", d, 32'hC5);
    reg_read(5'h10, d); chk(d == 0, "R8 unmapped reads 0", d, 0);

    // R9 start timing, ratio 4 on all channels (P=4)
    set_all(14'h0082);
    chk(out_clk_o == 1'b0, "R9 idle before start", out_clk_o, 0);
    reg_write(5'h00, 32'd1);
    step();
    chk(out_clk_o == 1'b1, "R9 high after first edge", out_clk_o, 1);
    repeat (4) step();
    reg_read(5'h04, d); chk(d == 0, "R9 running not yet", d, 0);
    step();
    reg_read(5'h04, d); chk(d == 1, "R9 running after period", d, 1);
    reg_read(5'h00, d); chk(d == 1, "R8 start reads back", d, 1);

    // R5 even symmetric
    expect_periods(0, 4, 4, 3, "R5 ratio 4");
    // R11 write while running has no effect
    reg_write(5'h08, 32'h00C5);
    expect_periods(0, 4, 4, 3, "R11 old word kept");

    // R10 stop: finish period, hold low
    reg_write(5'h00, 32'd0);
    wait_status(1'b0, n);
    chk(n <= 6, "R10 stop latency", n, 6);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      if (out_clk_o || fb_clk_o || in_clk_o) n++;
      #2;
    end
    chk(n == 0, "R10 outputs parked low", n, 0);

    // R11 new word after restart; R5 asymmetric 3/5
    start_run("R11 restart");
    expect_periods(0, 6, 10, 3, "R11 R5 asym word");
    stop_run("R10 stop");

    // R6 odd ratios with edge bit
    set_all(14'h20C4);
    start_run("R6 start");
    expect_periods(0, 7, 7, 3, "R6 ratio 7");
    stop_run("R10 stop");
    set_all(14'h2042);
    start_run("R6 start");
    expect_periods(0, 3, 3, 3, "R6 ratio 3");
    stop_run("R10 stop");

    // R7 bypass
    set_all(14'h1041);
    start_run("R7 start");
    expect_periods(0, 1, 1, 4, "R7 bypass");
    stop_run("R10 stop");

    // R5 field zero means 64
    set_all(14'h0000);
    start_run("R5 start");
    expect_periods(0, 128, 128, 2, "R5 ratio 128");
    stop_run("R10 stop");

    // R8 channel mapping
    reg_write(5'h08, 32'h0082);
    reg_write(5'h0C, 32'h00C5);
    reg_write(5'h14, 32'h20C4);
    start_run("R8 start");
    expect_periods(0, 4, 4, 2, "R8 out channel");
    expect_periods(1, 6, 10, 2, "R8 fb channel");
    expect_periods(2, 7, 7, 2, "R8 in channel");
    stop_run("R10 stop");

    summary();
  end
endmodule